// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block lets synchronous logic use an external static memory of 4096 one-bit words that has no clock. The memory has a 12-bit address, a data-in pin, a separate three-state data-out pin, and two active-low strobes, one for chip enable and one for write enable. The host presents one request at a time: an address, a write flag and a write bit. The controller then drives the strobes, the address and the data-in pin to the memory. Each phase is stretched to a whole number of clock cycles, so every minimum timing limit of the memory is met.

Each timing limit is a parameter given in nanoseconds. At elaboration it is converted to a cycle count by dividing by the clock period and rounding up. A write holds both strobes low for the longest of these limits: write pulse, address-to-write-end, enable-to-write-end, enable pulse and data setup. The address and data are then held with the memory deselected for the hold time or for the rest of the minimum cycle, whichever is longer. A read holds enable low, with write enable high, for the access time or the enable pulse, whichever is longer. The output is captured on the edge that ends that window. The memory is then deselected for at least one cycle. A done strobe marks the end of each access, and read data is valid with it.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While rst_ni is low and on the first cycle after reset, mem_ce_no and mem_we_no are 1, rsp_done_o is 0 and req_ready_o is 1.
- R2: req_ready_o is 1 only when the controller is idle and the memory is deselected. A request presented while req_ready_o is 0 is not taken and leaves the memory contents unchanged. Only one access is ever in progress.
- R3: A write (req_write_i = 1) drives mem_ce_no and mem_we_no low together for exactly C_WR cycles. C_WR is the largest of ceil(t/CLK_NS) over the write pulse, address-to-write-end, enable-to-write-end, enable pulse and data setup limits; the default is 36. Address and data stay constant throughout that window.
- R4: mem_we_no is never low while mem_ce_no is high, and it is never low during a read.
- R5: After write enable rises, mem_addr_o and mem_din_o keep the written values with the memory deselected until the next access begins. That is at least max(ceil(address hold), ceil(data hold), C_CYC - C_WR) cycles; the default is 8.
- R6: A read (req_write_i = 0) holds mem_ce_no low with mem_we_no high for exactly C_RD = max(ceil(access time), ceil(enable pulse)) cycles; the default is 40. mem_dout_i is captured on the edge that ends that window, and rsp_rdata_o returns the bit last written to that address, with the same polarity.
- R7: rsp_done_o is a single-cycle pulse, one per accepted access. It rises on the edge that ends the strobe window.
- R8: Between two accesses, mem_ce_no stays high for at least the tail count of the previous access plus the idle cycle, and always for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | 1 | Bit to write |
| req_ready_o | output | 1 | Controller idle; request taken on this edge if valid |
| rsp_done_o | output | 1 | Access finished (one-cycle pulse) |
| rsp_rdata_o | output | 1 | Read data, valid with rsp_done_o on a read |
| mem_addr_o | output | ADDR_W | Address to the memory |
| mem_din_o | output | 1 | Data-in pin of the memory |
| mem_dout_i | input | 1 | Data-out pin of the memory |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_we_no | output | 1 | Write enable, active low |

## Verification
The host can present a new request in the same cycle that the controller is still closing the previous access, whether in the done edge or in the deselected tail. The bench provokes this by raising the next request right after each done pulse, and by driving a write to a second address while a read is still in progress. It judges the result in three ways. Request ready must stay low until the tail has elapsed. The enable-high gap before the next strobe window must match the tail of the previous access. A later read of the second address must show that the write made during the busy period never reached the memory. A behavioural memory in the bench returns inverted data until the access time has elapsed, so a capture one cycle early is caught.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_STRB = 2'd1,
    PH_TAIL = 2'd2
  } phase_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned usub0(input int unsigned a, input int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R3
  load_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));

  // R6
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && expired_o) |=> expired_o);

endmodule

// File: rtl/sram_io_latch.sv
`timescale 1ns/1ps
module sram_io_latch #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_i,
  input  logic              capture_i,
  input  logic              mem_dout_i,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              din_o,
  output logic              rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_o <= 1'b0;
      addr_o  <= '0;
      din_o   <= 1'b0;
    end else if (accept_i) begin
      write_o <= write_i;
      addr_o  <= addr_i;
      din_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= 1'b0;
    else if (capture_i) rdata_o <= mem_dout_i;
  end

  // R5
  addr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(addr_o) && $stable(din_o));

  // R6
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> rdata_o == $past(mem_dout_i));

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CLK_NS   = 5,
  parameter int unsigned T_CYC_NS = 200,
  parameter int unsigned T_ACC_NS = 200,
  parameter int unsigned T_WP_NS  = 125,
  parameter int unsigned T_AW_NS  = 160,
  parameter int unsigned T_CW_NS  = 160,
  parameter int unsigned T_CE_NS  = 180,
  parameter int unsigned T_DS_NS  = 100,
  parameter int unsigned T_AH_NS  = 40,
  parameter int unsigned T_DH_NS  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_done_o,
  output logic              rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_din_o,
  input  logic              mem_dout_i,
  output logic              mem_ce_no,
  output logic              mem_we_no
);

  localparam int unsigned PER     = (CLK_NS == 0) ? 1 : CLK_NS;
  localparam int unsigned C_CYC   = ns_to_cyc(T_CYC_NS, PER);
  localparam int unsigned C_ACC   = ns_to_cyc(T_ACC_NS, PER);
  localparam int unsigned C_WP    = ns_to_cyc(T_WP_NS,  PER);
  localparam int unsigned C_AW    = ns_to_cyc(T_AW_NS,  PER);
  localparam int unsigned C_CW    = ns_to_cyc(T_CW_NS,  PER);
  localparam int unsigned C_CE    = ns_to_cyc(T_CE_NS,  PER);
  localparam int unsigned C_DS    = ns_to_cyc(T_DS_NS,  PER);
  localparam int unsigned C_AH    = ns_to_cyc(T_AH_NS,  PER);
  localparam int unsigned C_DH    = ns_to_cyc(T_DH_NS,  PER);
  localparam int unsigned C_WR    = umax(umax(C_WP, C_AW), umax(umax(C_CW, C_CE), C_DS));
  localparam int unsigned C_RD    = umax(C_ACC, C_CE);
  localparam int unsigned C_WTAIL = umax(1, umax(umax(C_AH, C_DH), usub0(C_CYC, C_WR)));
  localparam int unsigned C_RTAIL = umax(1, usub0(C_CYC, C_RD));
  localparam int unsigned C_MAX   = umax(umax(C_WR, C_RD), umax(C_WTAIL, C_RTAIL));
  localparam int unsigned CNT_W   = $clog2(C_MAX + 1);

  localparam logic [CNT_W-1:0] LV_WR    = CNT_W'(C_WR - 1);
  localparam logic [CNT_W-1:0] LV_RD    = CNT_W'(C_RD - 1);
  localparam logic [CNT_W-1:0] LV_WTAIL = CNT_W'(C_WTAIL - 1);
  localparam logic [CNT_W-1:0] LV_RTAIL = CNT_W'(C_RTAIL - 1);

  if (CLK_NS == 0 || C_WR < 1 || C_RD < 1 ||
      (T_ACC_NS != 0 && C_ACC < 1) || (T_WP_NS != 0 && C_WP < 1)) begin : g_bad_timing
    $error("sram_seq_ctrl: timing limit converts to fewer than one cycle");
  end

  phase_e           phase_q;
  logic             accept;
  logic             expired;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             capture;
  logic             wr_q;

  assign req_ready_o = (phase_q == PH_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign capture     = (phase_q == PH_STRB) && expired && !wr_q;
  assign load        = accept || ((phase_q == PH_STRB) && expired);

  always_comb begin
    if (accept) load_val = req_write_i ? LV_WR : LV_RD;
    else        load_val = wr_q ? LV_WTAIL : LV_RTAIL;
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  sram_io_latch #(.ADDR_W(ADDR_W)) u_io (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .write_i    (req_write_i),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .capture_i  (capture),
    .mem_dout_i (mem_dout_i),
    .write_o    (wr_q),
    .addr_o     (mem_addr_o),
    .din_o      (mem_din_o),
    .rdata_o    (rsp_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      mem_ce_no  <= 1'b1;
      mem_we_no  <= 1'b1;
      rsp_done_o <= 1'b0;
    end else begin
      rsp_done_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q   <= PH_STRB;
          mem_ce_no <= 1'b0;
          mem_we_no <= !req_write_i;
        end
        PH_STRB: if (expired) begin
          phase_q    <= PH_TAIL;
          mem_ce_no  <= 1'b1;
          mem_we_no  <= 1'b1;
          rsp_done_o <= 1'b1;
        end
        PH_TAIL: if (expired) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R4
  we_in_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !mem_ce_no);

  // R2
  ready_desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> mem_ce_no);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);

  // R8
  ce_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> $past(mem_ce_no, 2));

  // R3
  strobe_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o) && $stable(mem_din_o) && $stable(mem_we_no));

endmodule

// File: tb/sram_seq_ctrl_test.sv
`timescale 1ns/1ps
module sram_seq_ctrl_test;

  localparam int CLK_NS = 5;
  localparam int AW     = 12;
  localparam int DEPTH  = 4096;

  function automatic int cdiv(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_WR    = mx(mx(cdiv(125), cdiv(160)), mx(cdiv(180), cdiv(100)));
  localparam int E_RD    = mx(cdiv(200), cdiv(180));
  localparam int E_WTAIL = mx(mx(cdiv(40), cdiv(5)), mx(1, cdiv(200) - E_WR));
  localparam int E_RTAIL = mx(1, cdiv(200) - E_RD);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_wdata = 1'b0;
  logic          req_ready, rsp_done, rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_din, mem_dout, ce_n, we_n;

  always #2.5 clk = ~clk;

  sram_seq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_ready_o(req_ready), .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_din_o(mem_din), .mem_dout_i(mem_dout),
    .mem_ce_no(ce_n), .mem_we_no(we_n)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural memory: output inverted until access time has elapsed
  logic model_mem [DEPTH];
  logic exp_mem   [DEPTH];
  int   age;
  logic prev_we;

  assign mem_dout = (!ce_n && we_n && age >= E_RD - 1) ? model_mem[mem_addr] : ~model_mem[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      age     <= 0;
      prev_we <= 1'b1;
    end else begin
      age     <= (!ce_n && we_n) ? age + 1 : 0;
      prev_we <= we_n;
      if (we_n && !prev_we) model_mem[mem_addr] <= mem_din;
    end
  end

  // port monitor
  int            low_cnt = 0, high_cnt = 0;
  bit            cur_wr = 0, last_wr = 0, had_acc = 0, done_prev = 0;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_din = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ce_n) begin
        if (low_cnt == 0) begin
          if (had_acc)
            chk(high_cnt >= (last_wr ? E_WTAIL : E_RTAIL) + 1, "R8 enable-high gap", high_cnt,
                (last_wr ? E_WTAIL : E_RTAIL) + 1);
          cur_wr   = !we_n;
          acc_addr = mem_addr;
          acc_din  = mem_din;
        end else begin
          if (mem_addr != acc_addr) chk(0, "R3 address moved in strobe", int'(mem_addr), int'(acc_addr));
          if (cur_wr && mem_din != acc_din) chk(0, "R3 data moved in strobe", mem_din, acc_din);
          if (cur_wr == we_n) chk(0, "R4 write enable level", we_n, !cur_wr);
        end
        if (req_ready) chk(0, "R2 ready while selected", req_ready, 0);
        low_cnt++;
        high_cnt = 0;
      end else begin
        if (low_cnt > 0) begin
          chk(low_cnt == (cur_wr ? E_WR : E_RD), cur_wr ? "R3 write strobe length" : "R6 read strobe length",
              low_cnt, cur_wr ? E_WR : E_RD);
          had_acc = 1;
          last_wr = cur_wr;
          low_cnt = 0;
        end
        if (!we_n) chk(0, "R4 write enable without chip enable", we_n, 1);
        if (had_acc && last_wr && (mem_addr != acc_addr || mem_din != acc_din))
          chk(0, "R5 write hold", int'(mem_addr), int'(acc_addr));
        high_cnt++;
      end
      if (rsp_done && done_prev) chk(0, "R7 done wider than one cycle", 2, 1);
      done_prev = rsp_done;
    end
  end

  int n_done = 0, n_acc = 0;
  always @(posedge clk) if (rst_n && rsp_done) n_done++;

  task automatic access(input bit wr, input logic [AW-1:0] a, input bit d, output bit rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n_acc++;
    while (!rsp_done) @(negedge clk);
    rd = rsp_rdata;
    if (wr) exp_mem[a] = d;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input bit d);
    bit r;
    access(1'b1, a, d, r);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag);
    bit r;
    access(1'b0, a, 1'b0, r);
    chk(r == exp_mem[a], tag, r, exp_mem[a]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  logic [AW-1:0] pool [16];

  initial begin : main
    void'($urandom(32'd20251));
    for (int i = 0; i < DEPTH; i++) begin
      model_mem[i] = 1'b0;
      exp_mem[i]   = 1'b0;
    end
    for (int i = 0; i < 16; i++) pool[i] = AW'($urandom);

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(ce_n == 1'b1, "R1 chip enable in reset", ce_n, 1);
    chk(we_n == 1'b1, "R1 write enable in reset", we_n, 1);
    chk(rsp_done == 1'b0, "R1 done in reset", rsp_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && ce_n && we_n, "R1 idle after reset", req_ready, 1);

    // directed corners: address extremes, both polarities
    do_write(12'h000, 1'b1);
    do_write(12'hFFF, 1'b1);
    do_read(12'h000, "R6 read low corner");
    do_read(12'hFFF, "R6 read high corner");
    do_write(12'hFFF, 1'b0);
    do_read(12'hFFF, "R6 overwrite to zero");
    do_read(12'h555, "R6 never-written reads zero");

    // R2 request while busy is ignored
    begin
      logic [AW-1:0] va, vb;
      va = 12'h123; vb = 12'h456;
      do_write(vb, 1'b0);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = va; req_wdata = 1'b0;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      n_acc++;
      req_write = 1'b1; req_addr = vb; req_wdata = 1'b1;
      repeat (10) begin
        chk(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
        @(negedge clk);
      end
      req_valid = 1'b0;
      while (!rsp_done) @(negedge clk);
      do_read(vb, "R2 busy-time write had no effect");
    end

    // constrained random mix
    for (int k = 0; k < 150; k++) begin
      logic [AW-1:0] a;
      a = ($urandom % 2) ? pool[$urandom % 16] : AW'($urandom);
      if ($urandom % 2) do_write(a, 1'($urandom));
      else              do_read(a, "R6 random read");
    end

    repeat (E_WTAIL + 4) @(negedge clk);
    chk(n_done == n_acc, "R7 one done per access", n_done, n_acc);
    chk(req_ready && ce_n, "R2 idle at end", req_ready, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule